// File: doc/BRIEF.md
# Two-Channel Serial Controller Host Register Interface

This block is the byte-wide host side of a two-channel serial controller. The host sees four byte locations: a control port and a data port for each channel. Registers behind the control port are reached through a pointer. A control write made while the pointer is zero loads the pointer and can also issue a command. The next control access then reaches the chosen register, and that access puts the pointer back to zero. Each channel keeps its own bank of write registers and status read registers.

The serial engine is outside this block. It reports events through single-cycle strobes: a character has arrived (the character comes with the strobe), the transmitter has emptied, or a break was seen. A byte the host writes to a data port leaves on a one-cycle transmit strobe. The block tracks receive and transmit interrupt pending and under-service state for each channel. It posts a shared interrupt vector and a shared pending register across the two channels, and it merges both channels into one registered interrupt request.

Top module: `sccr_host_regs`

## Requirements
- R1: `host_addr[0]` selects the control port (0) or the data port (1). `host_addr[1]` selects channel B (0) or channel A (1). An access lasts one cycle, takes effect at the clock edge that ends it, and moves one byte.
- R2: A control write made while the pointer is 0 loads `wdata[2:0]` into the pointer. If command field `wdata[5:3]` is 001, 8 is added to that value. Any control write to a non-zero pointer, and any control read, leaves the pointer at 0. A control read returns the read register the pointer selects.
- R3: After reset each channel reads 0x44 at read register 0 and 0x07 at read register 1. Every other read register reads 0. Break interrupts are enabled (write register 15 bit 7 = 1) and status-high vectors are off (write register 9 bit 4 = 0).
- R4: A write to register 12 or 13 shows up at read register 12 or 13 of the same channel. Read registers 4 to 11, 14 and 15 read 0. Read register 2 reads 0 on channel A, and read register 3 reads 0 on channel B.
- R5: A receive strobe is taken only when write register 3 bit 0 is set and read register 0 bit 0 is clear. When taken, it sets read register 0 bit 0, stores the character and raises a receive interrupt. When not taken, it changes nothing.
- R6: A data read returns the stored character. It clears read register 0 bit 0 and the receive interrupt of that channel.
- R7: A data write, and also a transmit-empty strobe, sets read register 0 bit 2 and read register 1 bit 0 and raises a transmit interrupt. A data write with write register 5 bit 3 set pulses that channel's `tx_stb` bit for one cycle, starting the cycle after the write, with the byte on its `tx_char` slice.
- R8: `irq` is the OR, over both channels, of three terms: write register 1 bit 1 with transmit pending; write register 1 bits 4:3 equal to 01 or 10 with receive pending; write register 15 bit 7 with read register 0 bit 7. `irq` changes one clock after the strobe or access that changes it.
- R9: The vector at channel B read register 2 takes the latest posted code. With status-high off the codes are: none 0x06, receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00. With status-high on they are: none 0x60, receive A 0x30, receive B 0x20, transmit A 0x10, transmit B 0x00.
- R10: Channel A read register 3 holds the pending bits: bit 5 receive A, bit 4 transmit A, bit 2 receive B, bit 1 transmit B. A transmit bit is set only while write register 1 bit 1 is set.
- R11: Receive comes first. A transmit interrupt is not put under service while a receive is under service. Command 111 clears the receive under-service flag if it is set, and then presents any pending transmit; otherwise it clears the transmit under-service flag. A data read that clears the receive also presents any pending transmit.
- R12: Command 101 clears the transmit interrupt and its pending bit, posts the "none" vector, and then presents any pending receive.
- R13: Writing register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A, and 11 resets both. With 00 the byte is stored. Resetting channel B also clears the vector.
- R14: A break strobe sets read register 0 bit 7. The bit stays set until that channel is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Host access strobe, one cycle per byte |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Bit 0: control/data, bit 1: channel (1 = A) |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid during a read access, otherwise 0 |
| rx_stb | input | 2 | Character-received strobe per channel (bit 1 = A) |
| rx_char | input | 16 | Received characters, channel B in [7:0], A in [15:8] |
| txe_stb | input | 2 | Transmitter-empty strobe per channel |
| brk_stb | input | 2 | Break-detected strobe per channel |
| tx_stb | output | 2 | Transmit byte strobe per channel |
| tx_char | output | 16 | Transmit bytes, channel B in [7:0], A in [15:8] |
| irq | output | 1 | Merged interrupt request, registered |

## Verification
A wrong pending or under-service flag shows up in several ways: `irq` one clock after the event, the vector or pending byte on the next control read, or a vector that fails to move when the other interrupt kind is cleared. A pointer that fails to return to zero makes the very next control read return a register other than status. A reset command that reaches the wrong channel becomes visible as soon as the time-constant mirror of either channel is read back. The stimulus builds up receive and transmit interrupts on the same channel so that the priority handover can be seen step by step through the vector and pending registers.

// File: rtl/sccr_pkg.sv
`timescale 1ns/1ps
package sccr_pkg;

    parameter int unsigned SC_DW   = 8;
    parameter int unsigned SC_NREG = 16;
    parameter int unsigned SC_NCH  = 2;
    localparam int unsigned SC_PW  = $clog2(SC_NREG);
    localparam int unsigned SC_PND = 3 * SC_NCH;

    typedef logic [SC_DW-1:0] byte_t;

    // write register slots whose behaviour the block depends on
    localparam int unsigned RG_IRQEN = 1;
    localparam int unsigned RG_RXCFG = 3;
    localparam int unsigned RG_FRAME = 4;
    localparam int unsigned RG_TXCFG = 5;
    localparam int unsigned RG_MCTL  = 9;
    localparam int unsigned RG_CLKS  = 11;
    localparam int unsigned RG_TCLO  = 12;
    localparam int unsigned RG_TCHI  = 13;
    localparam int unsigned RG_MISC  = 14;
    localparam int unsigned RG_EXTEN = 15;

    localparam int unsigned RD_VEC  = 2;
    localparam int unsigned RD_PEND = 3;

    localparam logic [2:0] CMD_HIGH  = 3'b001;
    localparam logic [2:0] CMD_TXCLR = 3'b101;
    localparam logic [2:0] CMD_IUS   = 3'b111;

    typedef enum logic [1:0] {VK_NONE, VK_RX, VK_TX} vkind_e;

    typedef struct packed {
        logic [SC_NCH-1:0][SC_NREG-1:0][SC_DW-1:0] wr;
        logic [SC_NCH-1:0][SC_PW-1:0]              ptr;
        logic [SC_NCH-1:0][SC_DW-1:0]              st0;
        logic [SC_NCH-1:0][SC_DW-1:0]              st1;
        logic [SC_NCH-1:0][SC_DW-1:0]              tclo;
        logic [SC_NCH-1:0][SC_DW-1:0]              tchi;
        logic [SC_NCH-1:0][SC_DW-1:0]              rxbuf;
        logic [SC_NCH-1:0][SC_DW-1:0]              txd;
        logic [SC_NCH-1:0]                         rxint;
        logic [SC_NCH-1:0]                         txint;
        logic [SC_NCH-1:0]                         rxsvc;
        logic [SC_NCH-1:0]                         txsvc;
        logic [SC_NCH-1:0]                         txv;
        byte_t                                     vec;
        logic [SC_PND-1:0]                         pend;
    } regs_t;

    // vector code for an event on channel A (chan_a=1) or B
    function automatic byte_t vec_code(vkind_e k, logic chan_a, logic hi);
        byte_t v;
        case (k)
            VK_RX:   v = hi ? (chan_a ? 8'h30 : 8'h20) : (chan_a ? 8'h0C : 8'h04);
            VK_TX:   v = chan_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
            default: v = hi ? 8'h60 : 8'h06;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sccr_addr_dec.sv
`timescale 1ns/1ps
module sccr_addr_dec #(
    parameter int unsigned NCH = 2,
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          sel,
    input  logic          wr,
    input  logic [CW:0]   addr,
    output logic          ctrl_wr,
    output logic          ctrl_rd,
    output logic          data_wr,
    output logic          data_rd,
    output logic [CW-1:0] chan
);
    logic is_data;

    always_comb begin
        is_data = addr[0];
        chan    = addr[CW:1];
        ctrl_wr = sel &  wr & ~is_data;
        ctrl_rd = sel & ~wr & ~is_data;
        data_wr = sel &  wr &  is_data;
        data_rd = sel & ~wr &  is_data;
    end
endmodule

// File: rtl/sccr_read_mux.sv
`timescale 1ns/1ps
module sccr_read_mux
    import sccr_pkg::*;
(
    input  logic                         chan,
    input  logic                         rd_ctrl,
    input  logic                         rd_data,
    input  logic [SC_PW-1:0]             ptr_sel,
    input  logic [SC_NCH-1:0][SC_DW-1:0] st0,
    input  logic [SC_NCH-1:0][SC_DW-1:0] st1,
    input  logic [SC_NCH-1:0][SC_DW-1:0] tclo,
    input  logic [SC_NCH-1:0][SC_DW-1:0] tchi,
    input  logic [SC_NCH-1:0][SC_DW-1:0] rxbuf,
    input  byte_t                        vec,
    input  logic [SC_PND-1:0]            pend,
    output byte_t                        rdata
);
    localparam int unsigned PADW = SC_DW - SC_PND;

    byte_t ctrl_val;

    always_comb begin
        case (int'(ptr_sel))
            0:        ctrl_val = st0[chan];
            1:        ctrl_val = st1[chan];
            RD_VEC:   ctrl_val = chan ? '0 : vec;
            RD_PEND:  ctrl_val = chan ? {{PADW{1'b0}}, pend} : '0;
            RG_TCLO:  ctrl_val = tclo[chan];
            RG_TCHI:  ctrl_val = tchi[chan];
            default:  ctrl_val = '0;
        endcase
        if (rd_data)      rdata = rxbuf[chan];
        else if (rd_ctrl) rdata = ctrl_val;
        else              rdata = '0;
    end
endmodule

// File: rtl/sccr_irq_term.sv
`timescale 1ns/1ps
module sccr_irq_term
    import sccr_pkg::*;
(
    input  byte_t en_cfg,
    input  byte_t ext_cfg,
    input  byte_t status,
    input  logic  rx_pend,
    input  logic  tx_pend,
    output logic  term
);
    logic rx_mode_on;

    always_comb begin
        rx_mode_on = (en_cfg[4:3] == 2'b01) || (en_cfg[4:3] == 2'b10);
        term = (en_cfg[1] & tx_pend)
             | (rx_mode_on & rx_pend)
             | (ext_cfg[7] & status[7]);
    end
endmodule

// File: rtl/sccr_host_regs.sv
`timescale 1ns/1ps
module sccr_host_regs
    import sccr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_sel,
    input  logic                     host_wr,
    input  logic [1:0]               host_addr,
    input  logic [SC_DW-1:0]         host_wdata,
    output logic [SC_DW-1:0]         host_rdata,
    input  logic [SC_NCH-1:0]        rx_stb,
    input  logic [SC_NCH*SC_DW-1:0]  rx_char,
    input  logic [SC_NCH-1:0]        txe_stb,
    input  logic [SC_NCH-1:0]        brk_stb,
    output logic [SC_NCH-1:0]        tx_stb,
    output logic [SC_NCH*SC_DW-1:0]  tx_char,
    output logic                     irq
);

    regs_t state_q, state_d;
    logic  irq_q, irq_d;

    logic ctrl_wr, ctrl_rd, data_wr, data_rd, chan;
    logic [SC_NCH-1:0] rx_on, tx_on, term;
    logic [SC_PW-1:0]  cur_ptr;
    logic [2:0]        cmd;
    int                hc;
    logic              wr_spare_unused;

    // ---------------- per-channel helper updates ----------------
    function automatic regs_t f_rst_ch(regs_t s, int c);
        s.wr[c]            = '0;
        s.wr[c][RG_FRAME]  = 8'h04;
        s.wr[c][RG_MCTL]   = 8'hC0;
        s.wr[c][RG_CLKS]   = 8'h08;
        s.wr[c][RG_MISC]   = 8'h30;
        s.wr[c][RG_EXTEN]  = 8'hF8;
        s.ptr[c]   = '0;
        s.st0[c]   = 8'h44;
        s.st1[c]   = 8'h07;
        s.tclo[c]  = '0;
        s.tchi[c]  = '0;
        s.rxbuf[c] = '0;
        s.txd[c]   = '0;
        s.rxint[c] = 1'b0;
        s.txint[c] = 1'b0;
        s.rxsvc[c] = 1'b0;
        s.txsvc[c] = 1'b0;
        s.txv[c]   = 1'b0;
        s.pend[3*c +: 3] = '0;
        if (c == 0) s.vec = '0;
        return s;
    endfunction

    function automatic regs_t f_set_rx(regs_t s, int c);
        s.rxint[c]      = 1'b1;
        s.rxsvc[c]      = 1'b1;
        s.pend[3*c + 2] = 1'b1;
        s.vec = vec_code(VK_RX, c[0], s.wr[c][RG_MCTL][4]);
        return s;
    endfunction

    function automatic regs_t f_set_tx(regs_t s, int c);
        s.txint[c] = 1'b1;
        if (!s.rxsvc[c]) begin
            s.txsvc[c] = 1'b1;
            if (s.wr[c][RG_IRQEN][1]) s.pend[3*c + 1] = 1'b1;
            s.vec = vec_code(VK_TX, c[0], s.wr[c][RG_MCTL][4]);
        end
        return s;
    endfunction

    function automatic regs_t f_clr_rx(regs_t s, int c);
        s.rxint[c]      = 1'b0;
        s.rxsvc[c]      = 1'b0;
        s.pend[3*c + 2] = 1'b0;
        s.vec = vec_code(VK_NONE, c[0], s.wr[c][RG_MCTL][4]);
        if (s.txint[c]) s = f_set_tx(s, c);
        return s;
    endfunction

    function automatic regs_t f_clr_tx(regs_t s, int c);
        s.txint[c]      = 1'b0;
        s.txsvc[c]      = 1'b0;
        s.pend[3*c + 1] = 1'b0;
        s.vec = vec_code(VK_NONE, c[0], s.wr[c][RG_MCTL][4]);
        if (s.rxint[c]) s = f_set_rx(s, c);
        return s;
    endfunction

    // ---------------- address decode ----------------
    sccr_addr_dec #(.NCH(SC_NCH)) i_dec (
        .sel     (host_sel),
        .wr      (host_wr),
        .addr    (host_addr),
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd),
        .data_wr (data_wr),
        .data_rd (data_rd),
        .chan    (chan)
    );

    // registered channel enables
    generate
        for (genvar g = 0; g < SC_NCH; g++) begin : g_en
            assign rx_on[g] = state_q.wr[g][RG_RXCFG][0];
            assign tx_on[g] = state_q.wr[g][RG_TXCFG][3];
        end
    endgenerate

    assign wr_spare_unused = ^state_q.wr;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d     = state_q;
        state_d.txv = '0;
        hc      = int'(chan);
        cur_ptr = state_q.ptr[hc];
        cmd     = host_wdata[5:3];

        if (ctrl_wr) begin
            if (cur_ptr == '0) begin
                state_d.ptr[hc] = {1'b0, host_wdata[2:0]};
                case (cmd)
                    CMD_HIGH:  state_d.ptr[hc][SC_PW-1] = 1'b1;
                    CMD_TXCLR: state_d = f_clr_tx(state_d, hc);
                    CMD_IUS: begin
                        if (state_d.rxsvc[hc]) begin
                            state_d.rxsvc[hc] = 1'b0;
                            if (state_d.txint[hc]) state_d = f_set_tx(state_d, hc);
                        end else if (state_d.txsvc[hc]) begin
                            state_d.txsvc[hc] = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end else begin
                if (int'(cur_ptr) == RG_MCTL) begin
                    case (host_wdata[7:6])
                        2'b01:   state_d = f_rst_ch(state_d, 0);
                        2'b10:   state_d = f_rst_ch(state_d, 1);
                        2'b11:   state_d = f_rst_ch(f_rst_ch(state_d, 0), 1);
                        default: state_d.wr[hc][RG_MCTL] = host_wdata;
                    endcase
                end else begin
                    state_d.wr[hc][cur_ptr] = host_wdata;
                    if (int'(cur_ptr) == RG_TCLO) state_d.tclo[hc] = host_wdata;
                    if (int'(cur_ptr) == RG_TCHI) state_d.tchi[hc] = host_wdata;
                end
                state_d.ptr[hc] = '0;
            end
        end

        if (ctrl_rd) state_d.ptr[hc] = '0;

        if (data_wr) begin
            state_d.txd[hc]    = host_wdata;
            state_d.txv[hc]    = tx_on[hc];
            state_d.st0[hc][2] = 1'b1;
            state_d.st1[hc][0] = 1'b1;
            state_d = f_set_tx(state_d, hc);
        end

        if (data_rd) begin
            state_d.st0[hc][0] = 1'b0;
            state_d = f_clr_rx(state_d, hc);
        end

        for (int c = 0; c < SC_NCH; c++) begin
            if (brk_stb[c]) state_d.st0[c][7] = 1'b1;
            if (rx_stb[c] && rx_on[c] && !state_d.st0[c][0]) begin
                state_d.st0[c][0] = 1'b1;
                state_d.rxbuf[c]  = rx_char[c*SC_DW +: SC_DW];
                state_d = f_set_rx(state_d, c);
            end
            if (txe_stb[c]) begin
                state_d.st0[c][2] = 1'b1;
                state_d.st1[c][0] = 1'b1;
                state_d = f_set_tx(state_d, c);
            end
        end
    end

    // ---------------- interrupt merge ----------------
    generate
        for (genvar g = 0; g < SC_NCH; g++) begin : g_irq
            sccr_irq_term i_term (
                .en_cfg  (state_d.wr[g][RG_IRQEN]),
                .ext_cfg (state_d.wr[g][RG_EXTEN]),
                .status  (state_d.st0[g]),
                .rx_pend (state_d.rxint[g]),
                .tx_pend (state_d.txint[g]),
                .term    (term[g])
            );
        end
    endgenerate

    assign irq_d = |term;

    // ---------------- registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= f_rst_ch(f_rst_ch(regs_t'('0), 0), 1);
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    // ---------------- read path and outputs ----------------
    sccr_read_mux i_rmux (
        .chan    (chan),
        .rd_ctrl (ctrl_rd),
        .rd_data (data_rd),
        .ptr_sel (cur_ptr),
        .st0     (state_q.st0),
        .st1     (state_q.st1),
        .tclo    (state_q.tclo),
        .tchi    (state_q.tchi),
        .rxbuf   (state_q.rxbuf),
        .vec     (state_q.vec),
        .pend    (state_q.pend),
        .rdata   (host_rdata)
    );

    assign tx_stb  = state_q.txv;
    assign tx_char = state_q.txd;
    assign irq     = irq_q;

endmodule

// File: rtl/sccr_host_regs_chk.sv
`timescale 1ns/1ps
module sccr_host_regs_chk
    import sccr_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         host_sel,
    input logic                         host_wr,
    input logic [1:0]                   host_addr,
    input logic [SC_NCH-1:0]            rx_stb,
    input logic [SC_NCH-1:0]            brk_stb,
    input logic [SC_NCH-1:0]            tx_stb,
    input logic                         irq,
    input logic [SC_NCH-1:0][SC_PW-1:0] ptr,
    input logic [SC_NCH-1:0][SC_DW-1:0] st0,
    input logic [SC_NCH-1:0]            rx_on,
    input logic [SC_NCH-1:0]            tx_on,
    input logic [SC_NCH-1:0]            rxint,
    input logic [SC_NCH-1:0]            txint,
    input byte_t                        vec
);

    // R8: a raised request always has a flag behind it
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|rxint) || (|txint) || st0[0][7] || st0[1][7]));

    // R9: the vector only ever carries a legal code
    assert_vec_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec inside {8'h00, 8'h04, 8'h06, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h30, 8'h60});

    generate
        for (genvar c = 0; c < SC_NCH; c++) begin : g_ch
            // R2
            assert_ctrl_read_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (host_sel && !host_wr && host_addr == 2'(2*c)) |=> (ptr[c] == '0));
            // R5
            assert_rx_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (rx_stb[c] && rx_on[c] && !st0[c][0]) |=> (st0[c][0] && rxint[c]));
            // R6
            assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (host_sel && !host_wr && host_addr == 2'(2*c+1) && !rx_stb[c])
                |=> (!st0[c][0] && !rxint[c]));
            // R7
            assert_tx_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (host_sel && host_wr && host_addr == 2'(2*c+1) && tx_on[c]) |=> tx_stb[c]);
            // R14
            assert_break_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
                brk_stb[c] |=> st0[c][7]);
        end
    endgenerate

endmodule

bind sccr_host_regs sccr_host_regs_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .rx_stb    (rx_stb),
    .brk_stb   (brk_stb),
    .tx_stb    (tx_stb),
    .irq       (irq),
    .ptr       (state_q.ptr),
    .st0       (state_q.st0),
    .rx_on     (rx_on),
    .tx_on     (tx_on),
    .rxint     (state_q.rxint),
    .txint     (state_q.txint),
    .vec       (state_q.vec)
);

// File: tb/test_sccr_host_regs.sv
`timescale 1ns/1ps
module test_sccr_host_regs;

    localparam int CB = 0;
    localparam int CA = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [1:0]  rx_stb = '0;
    logic [15:0] rx_char = '0;
    logic [1:0]  txe_stb = '0;
    logic [1:0]  brk_stb = '0;
    logic [1:0]  tx_stb;
    logic [15:0] tx_char;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    sccr_host_regs i_sccr_host_regs (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_stb(rx_stb), .rx_char(rx_char), .txe_stb(txe_stb), .brk_stb(brk_stb),
        .tx_stb(tx_stb), .tx_char(tx_char), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", t, act, exp);
        end
    endtask

    // monitor: pops expected read data while a read is on the bus
    always @(negedge clk) begin
        if (host_sel && !host_wr) begin
            if (exp_q.size() == 0) chk(host_rdata, 8'hxx, "R1 unexpected read");
            else chk(host_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic acc(input logic w, input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #0.5;
        host_sel = 1'b1; host_wr = w; host_addr = a; host_wdata = d;
        @(posedge clk); #0.5;
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        acc(1'b0, a, 8'h00);
    endtask

    task automatic wr_ctrl(input int c, input logic [7:0] v);
        acc(1'b1, 2'(c*2), v);
    endtask

    function automatic logic [7:0] ptr_byte(input int r);
        return 8'(r & 7) | ((r >= 8) ? 8'h08 : 8'h00);
    endfunction

    task automatic wreg(input int c, input int r, input logic [7:0] v);
        wr_ctrl(c, ptr_byte(r));
        wr_ctrl(c, v);
    endtask

    task automatic rreg(input int c, input int r, input logic [7:0] e, input string t);
        if (r != 0) wr_ctrl(c, ptr_byte(r));
        rd(2'(c*2), e, t);
    endtask

    task automatic rdat(input int c, input logic [7:0] e, input string t);
        rd(2'(c*2+1), e, t);
    endtask

    task automatic wdat(input int c, input logic [7:0] v);
        acc(1'b1, 2'(c*2+1), v);
    endtask

    task automatic pulse(input int kind, input int c, input logic [7:0] ch);
        @(posedge clk); #0.5;
        case (kind)
            0: begin rx_stb[c] = 1'b1; rx_char[c*8 +: 8] = ch; end
            1: txe_stb[c] = 1'b1;
            default: brk_stb[c] = 1'b1;
        endcase
        @(posedge clk); #0.5;
        rx_stb = '0; txe_stb = '0; brk_stb = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        chk({7'b0, irq}, {7'b0, e}, t);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;

        // reset state
        chk_irq(1'b0, "R3 irq after reset");
        rreg(CB, 0, 8'h44, "R3 B status");
        rreg(CA, 1, 8'h07, "R3 A status1");
        rreg(CB, 2, 8'h00, "R3 vector");
        rreg(CA, 3, 8'h00, "R3 pending");
        rreg(CA, 12, 8'h00, "R3 A tclo");

        // pointer returns to 0 after a read
        wr_ctrl(CB, 8'h01);
        rd(2'b00, 8'h07, "R2 pointed read");
        rd(2'b00, 8'h44, "R2 pointer back to 0");

        // mirrors and pointer high command
        wreg(CB, 12, 8'h5A);
        wreg(CB, 13, 8'hA5);
        rd(2'b00, 8'h44, "R2 pointer 0 after reg write");
        rreg(CB, 12, 8'h5A, "R4 mirror lo");
        rreg(CB, 13, 8'hA5, "R4 mirror hi");
        rreg(CB, 4, 8'h00, "R4 unmapped reads 0");
        rreg(CA, 2, 8'h00, "R4 vector absent on A");
        rreg(CB, 3, 8'h00, "R4 pending absent on B");

        // receive disabled: strobe ignored
        pulse(0, CB, 8'h11);
        chk_irq(1'b0, "R5 rx ignored irq");
        rreg(CB, 0, 8'h44, "R5 rx ignored status");

        // receive on B
        wreg(CB, 3, 8'h01);
        wreg(CB, 1, 8'h10);
        @(posedge clk); #0.5;
        rx_stb[CB] = 1'b1; rx_char[7:0] = 8'h3C;
        chk_irq(1'b0, "R8 irq not before edge");
        @(posedge clk); #0.5;
        rx_stb = '0;
        chk_irq(1'b1, "R8 irq one clock after rx");
        pulse(0, CB, 8'h99);
        rreg(CB, 0, 8'h45, "R5 rx available");
        rreg(CB, 2, 8'h04, "R9 vector rx B");
        rreg(CA, 3, 8'h04, "R10 pending rx B");
        rdat(CB, 8'h3C, "R6 data read first char kept");
        chk_irq(1'b0, "R6 irq cleared by read");
        rreg(CB, 0, 8'h44, "R6 status cleared");
        rreg(CB, 2, 8'h06, "R9 vector none");
        rreg(CA, 3, 8'h00, "R10 pending cleared");

        // transmit on A
        wreg(CA, 1, 8'h02);
        wreg(CA, 5, 8'h08);
        wdat(CA, 8'h77);
        @(negedge clk);
        chk({6'b0, tx_stb}, 8'h02, "R7 tx strobe A");
        chk(tx_char[15:8], 8'h77, "R7 tx byte A");
        chk({7'b0, irq}, 8'h01, "R8 tx irq");
        rreg(CB, 2, 8'h08, "R9 vector tx A");
        rreg(CA, 3, 8'h10, "R10 pending tx A");
        rreg(CA, 1, 8'h07, "R7 all sent");
        wr_ctrl(CA, 8'h28);
        chk_irq(1'b0, "R12 tx clear irq");
        rreg(CB, 2, 8'h06, "R12 vector none");
        rreg(CA, 3, 8'h00, "R12 pending cleared");

        // priority: receive then transmit on A
        wreg(CA, 1, 8'h12);
        wreg(CA, 3, 8'h01);
        pulse(0, CA, 8'h41);
        rreg(CB, 2, 8'h0C, "R9 vector rx A");
        pulse(1, CA, 8'h00);
        rreg(CB, 2, 8'h0C, "R11 tx held behind rx");
        rreg(CA, 3, 8'h20, "R11 tx pend not posted");
        wr_ctrl(CA, 8'h38);
        rreg(CB, 2, 8'h08, "R11 tx presented after IUS");
        rreg(CA, 3, 8'h30, "R11 both pending");
        rdat(CA, 8'h41, "R6 data A");
        rreg(CB, 2, 8'h08, "R11 vector tx after rx clear");
        rreg(CA, 3, 8'h10, "R11 only tx pending");
        chk_irq(1'b1, "R8 irq held by tx");
        wr_ctrl(CA, 8'h28);
        chk_irq(1'b0, "R12 irq low after tx clear");

        // status-high vectors on B
        wreg(CB, 9, 8'h10);
        pulse(0, CB, 8'h55);
        rreg(CB, 2, 8'h20, "R9 vector rx B high");
        rdat(CB, 8'h55, "R6 data B again");
        rreg(CB, 2, 8'h60, "R9 vector none high");

        // break
        pulse(2, CB, 8'h00);
        chk_irq(1'b1, "R8 break irq from reset enable");
        rreg(CB, 0, 8'hC4, "R14 break status");
        wreg(CB, 15, 8'h00);
        chk_irq(1'b0, "R8 break irq disabled");
        rreg(CB, 0, 8'hC4, "R14 break sticky");

        // reset commands
        wreg(CA, 12, 8'h33);
        wreg(CA, 9, 8'h40);
        rreg(CB, 0, 8'h44, "R13 B reset status");
        rreg(CB, 12, 8'h00, "R13 B reset mirror");
        rreg(CB, 2, 8'h00, "R13 B reset vector");
        rreg(CA, 12, 8'h33, "R13 A kept on B reset");
        pulse(2, CB, 8'h00);
        chk_irq(1'b1, "R3 break enable restored");
        wreg(CB, 9, 8'h80);
        rreg(CA, 12, 8'h00, "R13 A reset mirror");
        rreg(CB, 0, 8'hC4, "R13 B kept on A reset");
        wreg(CA, 9, 8'hC0);
        chk_irq(1'b0, "R13 both reset irq");
        rreg(CB, 0, 8'h44, "R13 both reset status");

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) chk(8'(exp_q.size()), 8'h00, "R1 reads left unchecked");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%h exp=%h", 8'h00, 8'h01);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule